// File: doc/BRIEF.md
# Dual External Interrupt Request Conditioner

This block turns active-low external interrupt pins into request flags for an interrupt controller. Each pin goes through a reset-to-high synchronizer. A software-controlled trigger-type bit then decides how that input is read. With the bit set, a high-to-low transition of the synchronized pin sets a sticky flag. That flag stays set until the controller strobes the acknowledge line for that input, which it does when it takes the interrupt. With the bit clear, the request is simply the inverted synchronized pin. Nothing is latched, so the request drops once the pin returns high.

Software sees each input as a two-bit control field: the trigger-type bit and the flag bit. The fields are packed side by side into one control word. Software writes that word to select trigger types and to set or clear latched flags. The interrupt controller reads the request vector.

Top module: `ext_irq_detect`

## Requirements
- R1: After synchronous reset, `ctrl_rd` and `irq_req` are all zero. Every input is in level mode, and the synchronizers hold the inactive (high) value.
- R2: Input i occupies bits `2i` and `2i+1` of the control word. Bit `2i` is its trigger type (1 = falling edge, 0 = low level) and bit `2i+1` is its flag. A write with `ctrl_wr_en` high loads the type bits, and they read back on the next cycle.
- R3: A trigger-type bit changes only in a cycle with `ctrl_wr_en` high.
- R4: In edge mode, a pin that falls from high to low sets the flag after the third rising clock edge following the change. The first two edges only carry the new value through the synchronizer.
- R5: In edge mode, a set flag stays set after the pin returns high until it is acknowledged or written.
- R6: In edge mode, `irq_ack[i]` high for one cycle with no new falling edge clears flag i on the next cycle.
- R7: In edge mode, a falling edge detected in the same cycle as `irq_ack[i]` leaves the flag set.
- R8: In level mode, the flag and the request equal the inverted synchronized pin. They rise two clock edges after the pin goes low and fall two edges after it goes high, and `irq_ack` has no effect.
- R9: A write of the flag bit in edge mode takes precedence over a simultaneous `irq_ack`. In level mode a written flag value is ignored and the flag still follows the pin.
- R10: `irq_req[i]` always equals the flag bit `2i+1` of `ctrl_rd`.
- R11: In edge mode, a pin held low sets the flag only once. After an acknowledge, the flag stays clear while the pin stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | N_IN | Asynchronous active-low interrupt pins |
| ctrl_wr_en | input | 1 | Control word write strobe |
| ctrl_wr_data | input | 2*N_IN | Control word write value (type and flag per input) |
| irq_ack | input | N_IN | Per-input clear strobe from the interrupt controller |
| ctrl_rd | output | 2*N_IN | Control word read value |
| irq_req | output | N_IN | Per-input interrupt request |

## Verification
The bench builds the block with its defaults: two inputs and a two-stage synchronizer. With these values all four trigger-type combinations and every pin and acknowledge pattern fit in a few thousand cycles. Directed sequences pin down the exact cycle on which a flag sets or a request rises and falls. They also cover the collisions between a falling edge, an acknowledge and a software write. A pseudo-random sweep then drives pins, acknowledges and writes on both inputs together. It compares every cycle against a cycle model computed from the requirements.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_FALL  = 1'b1
    } trig_mode_e;

    // One per input: flag in the upper bit, trigger type in the lower bit.
    typedef struct packed {
        logic       flag;
        trig_mode_e mode;
    } chan_ctrl_t;

    localparam int CTRL_BITS = $bits(chan_ctrl_t);

    function automatic logic is_fall(logic prev_s, logic cur_s);
        return prev_s & ~cur_s;
    endfunction

    // Next value of the sticky edge flag; level mode keeps it empty.
    function automatic logic next_latch(trig_mode_e mode_nxt, logic fall,
                                        logic wr, logic wr_flag,
                                        logic cur_latch, logic ack);
        if (mode_nxt == TRIG_LEVEL) return 1'b0;
        if (fall)                   return 1'b1;
        if (wr)                     return wr_flag;
        return cur_latch & ~ack;
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_n,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    // One extra stage beyond the synchronizer gives the previous sample.
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[DEPTH-2:0], pin_n};
    end

    assign cur  = chain[STAGES-1];
    assign prev = chain[STAGES];
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_cur,
    input  logic       pin_prev,
    input  logic       wr_en,
    input  chan_ctrl_t wr_val,
    input  logic       ack,
    output chan_ctrl_t ctrl,
    output logic       req
);
    trig_mode_e mode_q, mode_d;
    logic       latch_q, latch_d, fall;

    always_comb begin
        fall    = is_fall(pin_prev, pin_cur);
        mode_d  = wr_en ? wr_val.mode : mode_q;
        latch_d = next_latch(mode_d, fall, wr_en, wr_val.flag, latch_q, ack);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= TRIG_LEVEL;
            latch_q <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            latch_q <= latch_d;
        end
    end

    always_comb begin
        ctrl.mode = mode_q;
        ctrl.flag = (mode_q == TRIG_FALL) ? latch_q : ~pin_cur;
    end

    assign req = ctrl.flag;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter int N_IN        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_IN-1:0]             irq_pin_n,
    input  logic                        ctrl_wr_en,
    input  logic [N_IN*CTRL_BITS-1:0]   ctrl_wr_data,
    input  logic [N_IN-1:0]             irq_ack,
    output logic [N_IN*CTRL_BITS-1:0]   ctrl_rd,
    output logic [N_IN-1:0]             irq_req
);
    logic [N_IN-1:0] sync_cur, sync_prev;

    ext_irq_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_n (irq_pin_n),
        .cur   (sync_cur),
        .prev  (sync_prev)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_chan
        chan_ctrl_t wr_val, rd_val;
        assign wr_val = chan_ctrl_t'(ctrl_wr_data[i*CTRL_BITS +: CTRL_BITS]);

        ext_irq_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .pin_cur  (sync_cur[i]),
            .pin_prev (sync_prev[i]),
            .wr_en    (ctrl_wr_en),
            .wr_val   (wr_val),
            .ack      (irq_ack[i]),
            .ctrl     (rd_val),
            .req      (irq_req[i])
        );

        assign ctrl_rd[i*CTRL_BITS +: CTRL_BITS] = rd_val;
    end
endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk #(
    parameter int N_IN = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              ctrl_wr_en,
    input logic [N_IN-1:0]   irq_ack,
    input logic [2*N_IN-1:0] ctrl_rd,
    input logic [N_IN-1:0]   irq_req,
    input logic [N_IN-1:0]   pin_cur,
    input logic [N_IN-1:0]   pin_prev
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ctrl_rd == '0) && (irq_req == '0));

    for (genvar i = 0; i < N_IN; i++) begin : g_chk
        // R3
        type_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !ctrl_wr_en |=> $stable(ctrl_rd[2*i]));

        // R4
        edge_set_chk: assert property (@(posedge clk) disable iff (rst)
            (!ctrl_wr_en && ctrl_rd[2*i] && pin_prev[i] && !pin_cur[i])
            |=> ctrl_rd[2*i+1]);

        // R5
        flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!ctrl_wr_en && ctrl_rd[2*i] && ctrl_rd[2*i+1] && !irq_ack[i])
            |=> ctrl_rd[2*i+1]);

        // R6
        ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (!ctrl_wr_en && ctrl_rd[2*i] && irq_ack[i] && !(pin_prev[i] && !pin_cur[i]))
            |=> !ctrl_rd[2*i+1]);

        // R8
        level_drop_chk: assert property (@(posedge clk) disable iff (rst)
            (!ctrl_rd[2*i] && pin_cur[i]) |-> !irq_req[i]);
    end
endmodule

bind ext_irq_detect ext_irq_detect_chk #(.N_IN(N_IN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr_en (ctrl_wr_en),
    .irq_ack    (irq_ack),
    .ctrl_rd    (ctrl_rd),
    .irq_req    (irq_req),
    .pin_cur    (sync_cur),
    .pin_prev   (sync_prev)
);

// File: tb/ext_irq_detect_tb.sv
module ext_irq_detect_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] pin_n = 2'b11;
    logic [1:0] ack = 2'b00;
    logic       wr = 1'b0;
    logic [3:0] wdata = 4'b0000;
    logic [3:0] rd;
    logic [1:0] req;
    bit         done = 1'b0;
    int         checks = 0;
    int         fails = 0;

    always #4 clk = ~clk;

    ext_irq_detect u_dut (
        .clk(clk), .rst(rst), .irq_pin_n(pin_n), .ctrl_wr_en(wr),
        .ctrl_wr_data(wdata), .irq_ack(ack), .ctrl_rd(rd), .irq_req(req)
    );

    // Cycle model built from the requirements.
    logic [1:0] m_s1, m_s2, m_prev, m_type, m_latch;

    function automatic logic m_next(logic nt, logic fall, logic w, logic wf,
                                    logic l, logic a);
        if (!nt) return 1'b0;
        if (fall) return 1'b1;
        if (w) return wf;
        return l & ~a;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 2'b11; m_s2 <= 2'b11; m_prev <= 2'b11;
            m_type <= 2'b00; m_latch <= 2'b00;
        end else begin
            m_s1 <= pin_n; m_s2 <= m_s1; m_prev <= m_s2;
            for (int i = 0; i < 2; i++) begin
                m_type[i]  <= wr ? wdata[2*i] : m_type[i];
                m_latch[i] <= m_next(wr ? wdata[2*i] : m_type[i],
                                     m_prev[i] & ~m_s2[i], wr, wdata[2*i+1],
                                     m_latch[i], ack[i]);
            end
        end
    end

    function automatic logic [3:0] exp_rd();
        logic [3:0] e;
        for (int i = 0; i < 2; i++) begin
            e[2*i]   = m_type[i];
            e[2*i+1] = m_type[i] ? m_latch[i] : ~m_s2[i];
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [3:0] act,
                       input logic [3:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    logic [15:0] lf = 16'hACE1;

    initial begin
        step(3);
        rst = 1'b0;
        chk(rd == 4'b0000 && req == 2'b00, "R1 reset state", rd, 4'b0000);

        wr = 1'b1; wdata = 4'b0101; step(1); wr = 1'b0;
        chk(rd == 4'b0101, "R2 type write", rd, 4'b0101);
        step(3);
        chk(rd == 4'b0101, "R3 types held", rd, 4'b0101);

        pin_n[0] = 1'b0; step(1);
        chk(rd[1] == 1'b0, "R4 edge after 1", {3'b0, rd[1]}, 4'b0);
        step(1);
        chk(rd[1] == 1'b0, "R4 edge after 2", {3'b0, rd[1]}, 4'b0);
        step(1);
        chk(rd[1] == 1'b1, "R4 edge after 3", {3'b0, rd[1]}, 4'b1);
        chk(req[0] == 1'b1, "R10 req follows flag", {3'b0, req[0]}, 4'b1);

        pin_n[0] = 1'b1; step(4);
        chk(rd[1] == 1'b1, "R5 flag latched", {3'b0, rd[1]}, 4'b1);

        ack = 2'b01; step(1); ack = 2'b00;
        chk(rd[1] == 1'b0 && req[0] == 1'b0, "R6 ack clears", {2'b0, req[0], rd[1]}, 4'b0);

        pin_n[0] = 1'b0; step(3);
        chk(rd[1] == 1'b1, "R11 first set", {3'b0, rd[1]}, 4'b1);
        ack = 2'b01; step(1); ack = 2'b00; step(4);
        chk(rd[1] == 1'b0, "R11 held low no reset", {3'b0, rd[1]}, 4'b0);
        pin_n[0] = 1'b1; step(3);

        wr = 1'b1; wdata = 4'b1101; step(1); wr = 1'b0;
        chk(rd == 4'b1101, "R9 edge flag write", rd, 4'b1101);
        pin_n[1] = 1'b0; step(2);
        ack = 2'b10; step(1); ack = 2'b00;
        chk(rd[3] == 1'b1, "R7 edge with ack", {3'b0, rd[3]}, 4'b1);
        pin_n[1] = 1'b1; step(3);

        wr = 1'b1; wdata = 4'b0111; ack = 2'b01; step(1); wr = 1'b0; ack = 2'b00;
        chk(rd[1] == 1'b1, "R9 write beats ack", {3'b0, rd[1]}, 4'b1);

        wr = 1'b1; wdata = 4'b1010; step(1); wr = 1'b0;
        chk(rd == 4'b0000 && req == 2'b00, "R9 level flag write ignored", rd, 4'b0000);

        pin_n[0] = 1'b0; step(1);
        chk(req[0] == 1'b0, "R8 level after 1", {3'b0, req[0]}, 4'b0);
        step(1);
        chk(req[0] == 1'b1 && rd[1] == 1'b1, "R8 level after 2", {2'b0, req[0], rd[1]}, 4'b0011);
        ack = 2'b01; step(1); ack = 2'b00;
        chk(req[0] == 1'b1, "R8 ack no effect", {3'b0, req[0]}, 4'b1);
        pin_n[0] = 1'b1; step(1);
        chk(req[0] == 1'b1, "R8 release after 1", {3'b0, req[0]}, 4'b1);
        step(1);
        chk(req[0] == 1'b0, "R8 not latched", {3'b0, req[0]}, 4'b0);

        for (int c = 0; c < 4000; c++) begin
            chk(rd == exp_rd(), "R5 sweep control word", rd, exp_rd());
            chk(req == {rd[3], rd[1]}, "R10 sweep request", {2'b0, req}, {2'b0, rd[3], rd[1]});
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            pin_n = lf[1:0];
            ack   = lf[5:4] & {lf[6], lf[7]};
            wr    = (lf[11:8] == 4'h0);
            wdata = lf[15:12];
            step(1);
        end
        wr = 1'b0; ack = 2'b00;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule